// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block moves a set of 32-bit registers to or from memory as one command. A command carries a base address, a 16-bit mask naming the registers to move, a direction (load or store), one of four addressing modes and a writeback enable. The engine then walks the mask one register per memory access. A store reads each register through a register-file read port and sends it out as write data. A load writes each returned word back through a register-file write port.

Registers always go in ascending order to ascending word addresses, whatever the mode. The mode only decides where the block starts and where the base ends up. A stack push is the decrement-before store with writeback. A stack pop is the increment-after load with writeback. When the block is finished the engine reports the final base value and raises a one-cycle done pulse, together with a flag that says whether the caller should write that base back.

The memory side is a single request/ready port: an access completes in any cycle in which both request and ready are high.

Top module: `blkxfer_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, mem_req, rf_we and done are all low.
- R2: A command makes exactly one memory access per set bit of the register mask. Register indices go in ascending order, and each access address is 4 above the one before it.
- R3: The first access address depends on cmd_mode, with n set bits: mode 0 (increment after) uses base, mode 1 (increment before) uses base+4, mode 2 (decrement after) uses base−4n+4, mode 3 (decrement before) uses base−4n.
- R4: With done high, base_out holds base+4n for modes 0 and 1 and base−4n for modes 2 and 3. base_we equals the command's writeback enable.
- R5: A store (cmd_load=0) drives mem_we high. mem_wdata equals the rf_rdata returned for the rf_raddr that names the current register.
- R6: A load (cmd_load=1) raises rf_we only in the cycles where an access completes. In those cycles rf_waddr is the current register and rf_wdata is mem_rdata. rf_we is never high for a store.
- R7: While mem_req is high and mem_ready is low, the next cycle keeps mem_req high with the same address and register.
- R8: An empty mask makes no memory access. done rises in the cycle after the command is accepted, and base_out equals the base.
- R9: cmd_valid is ignored while busy is high. The running transfer's accesses and final base are unaffected.
- R10: done lasts exactly one cycle, and busy is low in the cycle after it.
- R11: A 4-register push from base 0x03007F00 stores the lowest register at 0x03007EF0 and ends with base 0x03007EF0. A pop of the same registers from there restores their values and returns the base to 0x03007F00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken only while idle |
| cmd_base | input | 32 | Base address |
| cmd_list | input | 16 | Register mask, bit i selects register i |
| cmd_load | input | 1 | 1 = load from memory, 0 = store |
| cmd_mode | input | 2 | Addressing mode, 0..3 as in R3 |
| cmd_wb | input | 1 | Writeback enable for the final base |
| busy | output | 1 | Engine is not idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| base_out | output | 32 | Final base value |
| base_we | output | 1 | Writeback request, valid with done |

## Verification
The assertions take for granted two properties of the inputs. The register read port answers in the same cycle. Memory may hold off an access with mem_ready low for any number of cycles, but the bench keeps every hold short. The stimulus respects this: it raises mem_ready with a random 3-in-4 chance each cycle and forces it high for the directed cases. The stimulus also presents commands only while the engine is idle, except in the one deliberate busy-time command. That command is raised and dropped inside a cycle window in which the engine is known to be mid-transfer.

// File: rtl/blkxfer_pkg.sv
// Shared types for the block transfer sequencer.
// Assumes a 2-bit mode code whose upper bit selects the downward direction.
package blkxfer_pkg;
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MOVE   = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_t;

    localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/blkxfer_addr_plan.sv
// Computes the register count, the first access address and the final base of a command.
// Assumes word-sized slots; pure combinational logic, no state.
module blkxfer_addr_plan #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 16,
    localparam int unsigned CW  = $clog2(NREG + 1)
) (
    input  logic [XLEN-1:0]          base,
    input  logic [NREG-1:0]          list,
    input  blkxfer_pkg::addr_mode_t  mode,
    output logic [CW-1:0]            count,
    output logic [XLEN-1:0]          start_addr,
    output logic [XLEN-1:0]          final_base
);
    import blkxfer_pkg::*;

    logic [CW-1:0]   psum [NREG+1];
    logic [XLEN-1:0] span;
    logic [XLEN-1:0] word;

    assign psum[0] = '0;
    // Ripple population count over the mask.
    for (genvar g = 0; g < NREG; g++) begin : g_pop
        assign psum[g+1] = psum[g] + CW'(list[g]);
    end
    assign count = psum[NREG];
    assign span  = XLEN'(count) << WORD_SHIFT;
    assign word  = XLEN'(1) << WORD_SHIFT;

    // Start and end positions per addressing mode.
    always_comb begin
        unique case (mode)
            AM_INC_AFTER:  start_addr = base;
            AM_INC_BEFORE: start_addr = base + word;
            AM_DEC_AFTER:  start_addr = base - span + word;
            default:       start_addr = base - span;
        endcase
        final_base = mode[1] ? (base - span) : (base + span);
    end
endmodule

// File: rtl/blkxfer_pick.sv
// Selects the lowest set bit of the remaining mask and the mask left after it.
// Assumes nothing about the mask; outputs index 0 for an empty mask.
module blkxfer_pick #(
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] list,
    output logic [IW-1:0]   idx,
    output logic [NREG-1:0] rest,
    output logic            last
);
    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (list[i]) idx = IW'(i);
        end
    end
    assign rest = list & (list - NREG'(1));
    assign last = (rest == '0);
endmodule

// File: rtl/blkxfer_seq.sv
// Block transfer sequencer: one memory access per selected register, ascending.
// Assumes a combinational register read port and a request/ready memory port.
module blkxfer_seq #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 16,
    localparam int unsigned IW  = $clog2(NREG),
    localparam int unsigned CW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [XLEN-1:0] cmd_base,
    input  logic [NREG-1:0] cmd_list,
    input  logic            cmd_load,
    input  logic [1:0]      cmd_mode,
    input  logic            cmd_wb,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic [IW-1:0]   rf_raddr,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            rf_we,
    output logic [IW-1:0]   rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            done,
    output logic [XLEN-1:0] base_out,
    output logic            base_we
);
    import blkxfer_pkg::*;

    seq_state_t      state;
    logic [NREG-1:0] list_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] final_q;
    logic            load_q;
    logic            wb_q;

    logic [CW-1:0]   plan_count;
    logic [XLEN-1:0] plan_start;
    logic [XLEN-1:0] plan_final;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] rest;
    logic            last;
    logic            accept;
    logic            step;

    blkxfer_addr_plan #(.XLEN(XLEN), .NREG(NREG)) u_plan (
        .base       (cmd_base),
        .list       (cmd_list),
        .mode       (addr_mode_t'(cmd_mode)),
        .count      (plan_count),
        .start_addr (plan_start),
        .final_base (plan_final)
    );

    blkxfer_pick #(.NREG(NREG)) u_pick (
        .list (list_q),
        .idx  (cur_idx),
        .rest (rest),
        .last (last)
    );

    assign accept = (state == ST_IDLE) && cmd_valid;
    assign step   = (state == ST_MOVE) && mem_ready;

    // Sequencer state and per-command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            list_q  <= '0;
            addr_q  <= '0;
            final_q <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    list_q  <= cmd_list;
                    addr_q  <= plan_start;
                    final_q <= plan_final;
                    load_q  <= cmd_load;
                    wb_q    <= cmd_wb;
                    state   <= (plan_count == '0) ? ST_FINISH : ST_MOVE;
                end
                ST_MOVE: if (step) begin
                    list_q <= rest;
                    addr_q <= addr_q + (XLEN'(1) << WORD_SHIFT);
                    if (last) state <= ST_FINISH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the current state.
    assign busy      = (state != ST_IDLE);
    assign mem_req   = (state == ST_MOVE);
    assign mem_we    = mem_req && !load_q;
    assign mem_addr  = addr_q;
    assign rf_raddr  = cur_idx;
    assign mem_wdata = rf_rdata;
    assign rf_we     = step && load_q;
    assign rf_waddr  = cur_idx;
    assign rf_wdata  = mem_rdata;
    assign done      = (state == ST_FINISH);
    assign base_out  = final_q;
    assign base_we   = done && wb_q;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we && !done));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !last) |=>
            (mem_req && mem_addr == $past(mem_addr) + 32'd4));

    p_load_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ready && !mem_we));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(rf_raddr)));

    p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_list == '0) |=>
            (done && !mem_req && base_out == $past(cmd_base)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/blkxfer_seq_bench.sv
module blkxfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_list = '0;
    logic        cmd_load = 1'b0;
    logic [1:0]  cmd_mode = '0;
    logic        cmd_wb = 1'b0;
    logic        busy, mem_req, mem_we, rf_we, done, base_we;
    logic [31:0] mem_addr, mem_wdata, rf_wdata, base_out;
    logic [31:0] mem_rdata;
    logic        mem_ready = 1'b1;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    bit rand_ready = 1'b0;

    logic [31:0] rf [16];
    logic [31:0] mem_m [logic [31:0]];

    logic [31:0] acc_addr [16];
    logic [3:0]  acc_reg  [16];
    int          n_acc = 0;
    bit          hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;

    always #2.5 clk = ~clk;

    blkxfer_seq u_blkxfer_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_base(cmd_base),
        .cmd_list(cmd_list), .cmd_load(cmd_load), .cmd_mode(cmd_mode), .cmd_wb(cmd_wb),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .done(done), .base_out(base_out), .base_we(base_we)
    );

    function automatic logic [31:0] hash(input logic [31:0] a);
        return (a + 32'd1) * 32'h9E3779B9 ^ a;
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return hash(a);
    endfunction

    always @(mem_addr or wr_count) mem_rdata = mem_read(mem_addr);
    assign rf_rdata = rf[rf_raddr];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Memory ready pattern, updated just after each rising edge.
    always @(posedge clk) begin
        #1;
        mem_ready <= rand_ready ? (($urandom % 4) != 0) : 1'b1;
    end

    // Port monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && mem_req)
                check(mem_addr == hold_addr, "R7 hold address", mem_addr, hold_addr);
            hold_pend = mem_req && !mem_ready;
            hold_addr = mem_addr;
            if (rf_we && !(mem_req && mem_ready && !mem_we))
                check(1'b0, "R6 stray rf_we", 32'(rf_we), 32'd0);
            if (mem_req && mem_ready) begin
                if (n_acc < 16) begin
                    acc_addr[n_acc] = mem_addr;
                    acc_reg[n_acc]  = mem_we ? rf_raddr : rf_waddr;
                end
                n_acc++;
                if (mem_we) begin
                    check(mem_wdata == rf[rf_raddr], "R5 store data", mem_wdata, rf[rf_raddr]);
                    mem_m[mem_addr] = mem_wdata;
                    wr_count++;
                end else begin
                    check(rf_we == 1'b1, "R6 load strobe", 32'(rf_we), 32'd1);
                    check(rf_wdata == mem_read(mem_addr), "R6 load data",
                          rf_wdata, mem_read(mem_addr));
                    rf[rf_waddr] = rf_wdata;
                end
            end
        end
    end

    task automatic run(input logic [31:0] base, input logic [15:0] list, input bit load,
                       input logic [1:0] mode, input bit wb, input bit inject);
        int n;
        int waits;
        logic [31:0] start;
        logic [31:0] fin;
        int k;
        n = $countones(list);
        case (mode)
            2'd0: start = base;
            2'd1: start = base + 32'd4;
            2'd2: start = base - 32'(4 * n) + 32'd4;
            default: start = base - 32'(4 * n);
        endcase
        fin = mode[1] ? base - 32'(4 * n) : base + 32'(4 * n);
        @(posedge clk); #1;
        n_acc = 0;
        cmd_valid = 1'b1; cmd_base = base; cmd_list = list;
        cmd_load = load; cmd_mode = mode; cmd_wb = wb;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        waits = 0;
        while (1) begin
            @(negedge clk);
            waits++;
            if (inject && waits == 2 && busy && !done) begin
                cmd_valid = 1'b1; cmd_base = 32'h5555_0000; cmd_list = 16'h8001;
                cmd_load = ~load; cmd_mode = ~mode; cmd_wb = ~wb;
            end else cmd_valid = 1'b0;
            if (done) break;
            if (waits > 2000) begin
                check(1'b0, "watchdog", 32'(waits), 32'd0);
                break;
            end
        end
        cmd_valid = 1'b0;
        if (list == 16'h0)
            check(waits == 1, "R8 empty done timing", 32'(waits), 32'd1);
        check(n_acc == n, "R2 access count", 32'(n_acc), 32'(n));
        check(base_out == fin, "R4 final base", base_out, fin);
        check(base_we == wb, "R4 writeback flag", 32'(base_we), 32'(wb));
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (list[i] && k < n_acc && k < 16) begin
                check(acc_reg[k] == 4'(i), "R2 register order", 32'(acc_reg[k]), 32'(i));
                check(acc_addr[k] == start + 32'(4 * k),
                      (k == 0) ? "R3 start address" : "R2 address step",
                      acc_addr[k], start + 32'(4 * k));
                k++;
            end
        end
        @(negedge clk);
        check(!done && !busy, "R10 done pulse", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] saved [4];
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) rf[i] = hash(32'h100 + 32'(i));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req && !rf_we && !done, "R1 reset state",
              {28'd0, busy, mem_req, rf_we, done}, 32'd0);

        // R11 push then pop on the stack area.
        for (int i = 0; i < 4; i++) saved[i] = rf[i];
        run(32'h0300_7F00, 16'h000F, 1'b0, 2'd3, 1'b1, 1'b0);
        check(base_out == 32'h0300_7EF0, "R11 push base", base_out, 32'h0300_7EF0);
        check(mem_read(32'h0300_7EF0) == saved[0], "R11 lowest at lowest",
              mem_read(32'h0300_7EF0), saved[0]);
        for (int i = 0; i < 4; i++) rf[i] = hash(32'hBAD0 + 32'(i));
        run(32'h0300_7EF0, 16'h000F, 1'b1, 2'd0, 1'b1, 1'b0);
        check(base_out == 32'h0300_7F00, "R11 pop base", base_out, 32'h0300_7F00);
        for (int i = 0; i < 4; i++)
            check(rf[i] == saved[i], "R11 pop restore", rf[i], saved[i]);

        // R8 empty list, R3 every mode with a single and a full mask.
        run(32'h1000_0040, 16'h0000, 1'b0, 2'd2, 1'b1, 1'b0);
        for (int m = 0; m < 4; m++) begin
            run(32'h2000_0100, 16'h0400, 1'b1, 2'(m), 1'b0, 1'b0);
            run(32'h2000_0100, 16'hFFFF, 1'b0, 2'(m), 1'b1, 1'b0);
        end

        // R9 command during a busy transfer, with stalls.
        rand_ready = 1'b1;
        run(32'h4000_0200, 16'hF0F0, 1'b0, 2'd1, 1'b1, 1'b1);
        run(32'h4000_0300, 16'h8421, 1'b1, 2'd3, 1'b0, 1'b1);

        // Random commands with random stalls (R2..R7).
        for (int t = 0; t < 40; t++) begin
            run({$urandom} & 32'hFFFF_FFFC, 16'($urandom), 1'($urandom),
                2'($urandom), 1'($urandom), 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule